// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called side A and side B. It carries data either way, and it can also hold a word from each bus for later use. Each direction has its own capture register with its own clock. The A-to-B register samples the A bus, and the B-to-A register samples the B bus. Capture happens on every rising edge of the register's clock, whatever the selects and output enables are doing.

For each direction, a select line chooses what the driven side carries: the live word from the opposite bus, or the word held in that direction's register. Two output enables decide whether each side is driven. The B-side enable is active high and the A-side enable is active low.

The three-state pads are split into an input value, an output value and a drive flag per side, and the surrounding logic resolves the shared wire. A build-time parameter picks a data path that either passes the selected word unchanged or complements it. Complementing happens only on the way out; the held words are never inverted.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a rising edge of `clk_ab` with `rst_n` high, the A-to-B register takes the value on `a_in`.
- R2: On a rising edge of `clk_ba` with `rst_n` high, the B-to-A register takes the value on `b_in`.
- R3: Capture takes place whatever the values of `sel_ab`, `sel_ba`, `oe_b` and `oe_a_n`, including the isolation setting (`oe_b`=0, `oe_a_n`=1), where both drive flags are 0.
- R4: `b_drv` equals `oe_b` (active high) and `a_drv` equals the inverse of `oe_a_n` (active low).
- R5: While side B is driven, `sel_ab`=0 puts the live `a_in` word on `b_out`, and `sel_ab`=1 puts the A-to-B register on `b_out`.
- R6: While side A is driven, `sel_ba`=0 puts the live `b_in` word on `a_out`, and `sel_ba`=1 puts the B-to-A register on `a_out`.
- R7: With both sides driven and both selects at 0, each output follows the opposite input. If both buses carry the same word, both outputs return that word, so a bus with no other driver keeps its value.
- R8: With POLARITY set to POL_INVERT, each output is the bitwise complement of the selected word. The register itself keeps the uncomplemented value, so a held word `x` appears as `~x`. With POL_TRUE, the output equals the selected word.
- R9: A rising edge of a register's clock while `rst_n` is 0 clears that register to all zeros.
- R10: An edge on one register's clock leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Synchronous active-low clear, sampled on each register's own clock |
| a_in | input | WIDTH | Value seen on the A bus |
| b_in | input | WIDTH | Value seen on the B bus |
| sel_ab | input | 1 | B-side source: 0 live A, 1 held A |
| sel_ba | input | 1 | A-side source: 0 live B, 1 held B |
| oe_b | input | 1 | Drive side B, active high |
| oe_a_n | input | 1 | Drive side A, active low |
| a_out | output | WIDTH | Word presented to side A; don't-care when `a_drv` is 0 |
| a_drv | output | 1 | Side A drive flag |
| b_out | output | WIDTH | Word presented to side B; don't-care when `b_drv` is 0 |
| b_drv | output | 1 | Side B drive flag |

## Verification
A held word that is wrong does not show at the ports until that direction's select is 1 and its side is enabled. From then on it is visible on the same cycle, as a mismatch between `b_out` or `a_out` and the last word captured. For this reason the bench reads the stored data back after almost every random step, not only at the end. A fault in the enable decode or the live path shows on the same cycle the inputs change. The complemented build exposes any inversion applied at capture as a double complement on readback.

// File: rtl/xcvr_pkg.sv
// Package: shared polarity selection for the bus transceiver.
// Assumes: consumers compare against these enum values only.
package xcvr_pkg;
    typedef enum logic {
        POL_TRUE   = 1'b0,
        POL_INVERT = 1'b1
    } pol_e;
endpackage

// File: rtl/xcvr_stage_reg.sv
// Module: one direction's capture register.
// Samples d on every rising clk edge; a low rst_n on that edge clears it.
// Assumes: rst_n is synchronous to clk.
module xcvr_stage_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture or clear on each rising clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/xcvr_drive_sel.sv
// Module: output source choice plus optional complement for one side.
// sel=0 chooses the live word, sel=1 the held word; POLARITY applies on exit only.
// Assumes: purely combinational; the caller owns the drive flag.
module xcvr_drive_sel
    import xcvr_pkg::*;
#(
    parameter int   WIDTH    = 8,
    parameter pol_e POLARITY = POL_TRUE
) (
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] held,
    input  logic             sel,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] pick;

    // Choose between the opposite bus and the held register.
    always_comb pick = sel ? held : live;

    generate
        if (POLARITY == POL_INVERT) begin : g_inv
            // Complement the chosen word on its way to the pads.
            always_comb y = ~pick;
        end else begin : g_true
            // Pass the chosen word unchanged.
            always_comb y = pick;
        end
    endgenerate
endmodule

// File: rtl/bus_xcvr_reg.sv
// Module: registered bidirectional transceiver between buses A and B.
// Two independently clocked capture registers, one per direction, each with
// a live/held output choice. Pads are split into value and drive flag.
// Assumes: contention on the shared wires is resolved outside this block.
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int   WIDTH    = 8,
    parameter pol_e POLARITY = POL_TRUE
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             oe_b,
    input  logic             oe_a_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drv,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drv
);
    logic [WIDTH-1:0] stg_ab;
    logic [WIDTH-1:0] stg_ba;

    xcvr_stage_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(stg_ab)
    );

    xcvr_stage_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(stg_ba)
    );

    xcvr_drive_sel #(.WIDTH(WIDTH), .POLARITY(POLARITY)) u_sel_b (
        .live(a_in), .held(stg_ab), .sel(sel_ab), .y(b_out)
    );

    xcvr_drive_sel #(.WIDTH(WIDTH), .POLARITY(POLARITY)) u_sel_a (
        .live(b_in), .held(stg_ba), .sel(sel_ba), .y(a_out)
    );

    // Decode the two enables of opposite polarity into drive flags.
    always_comb begin
        b_drv = oe_b;
        a_drv = ~oe_a_n;
    end
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
// Module: assertion checker attached to bus_xcvr_reg by bind.
// Assumes: sampled on the register clocks; disabled while rst_n is low.
module bus_xcvr_reg_chk
    import xcvr_pkg::*;
#(
    parameter int   WIDTH    = 8,
    parameter pol_e POLARITY = POL_TRUE
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic             oe_b,
    input logic             oe_a_n,
    input logic [WIDTH-1:0] a_out,
    input logic             a_drv,
    input logic [WIDTH-1:0] b_out,
    input logic             b_drv,
    input logic [WIDTH-1:0] stg_ab,
    input logic [WIDTH-1:0] stg_ba
);
    localparam logic [WIDTH-1:0] FLIP = (POLARITY == POL_INVERT) ? '1 : '0;

    p_cap_ab_r1: assert property (@(posedge clk_ab) disable iff (!rst_n)
        1'b1 |=> stg_ab == $past(a_in));

    p_cap_ba_r2: assert property (@(posedge clk_ba) disable iff (!rst_n)
        1'b1 |=> stg_ba == $past(b_in));

    p_isolate_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_b && oe_a_n) |-> (!a_drv && !b_drv));

    p_drv_flags_r4: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (b_drv == oe_b) && (a_drv != oe_a_n));

    p_live_b_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!sel_ab && b_drv) |-> b_out == (a_in ^ FLIP));

    p_held_a_r6: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (sel_ba && a_drv) |-> a_out == (stg_ba ^ FLIP));

    p_held_b_r8: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (sel_ab && b_drv) |-> b_out == (stg_ab ^ FLIP));

    p_live_a_r7: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (!sel_ba && a_drv) |-> a_out == (b_in ^ FLIP));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH), .POLARITY(POLARITY)) u_chk (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .a_in(a_in), .b_in(b_in), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .oe_b(oe_b), .oe_a_n(oe_a_n), .a_out(a_out), .a_drv(a_drv),
    .b_out(b_out), .b_drv(b_drv), .stg_ab(stg_ab), .stg_ba(stg_ba)
);

// File: tb/bus_xcvr_reg_bench.sv
// Bench: directed corners plus seeded random stimulus against a reference model.
module bus_xcvr_reg_bench;
    import xcvr_pkg::*;
    localparam int W = 8;

    logic clk = 1'b0;
    logic clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic sel_ab = 1'b0, sel_ba = 1'b0, oe_b = 1'b0, oe_a_n = 1'b1;
    logic [W-1:0] a_out, b_out, a_out_i, b_out_i;
    logic a_drv, b_drv, a_drv_i, b_drv_i;
    logic [W-1:0] ref_ab = '0, ref_ba = '0;
    int total = 0, bad = 0, cycles = 0;

    always #2 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W), .POLARITY(POL_TRUE)) u_bus_xcvr_reg (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_b(oe_b), .oe_a_n(oe_a_n),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv));

    bus_xcvr_reg #(.WIDTH(W), .POLARITY(POL_INVERT)) u_bus_xcvr_reg_inv (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_b(oe_b), .oe_a_n(oe_a_n),
        .a_out(a_out_i), .a_drv(a_drv_i), .b_out(b_out_i), .b_drv(b_drv_i));

    function automatic logic [W-1:0] exp_b(input logic inv);
        logic [W-1:0] v = sel_ab ? ref_ab : a_in;
        return inv ? ~v : v;
    endfunction

    function automatic logic [W-1:0] exp_a(input logic inv);
        logic [W-1:0] v = sel_ba ? ref_ba : b_in;
        return inv ? ~v : v;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One step: optional register clock pulses aligned to clk, model updated alongside.
    task automatic tick(input logic do_ab, input logic do_ba);
        @(posedge clk);
        clk_ab = do_ab;
        clk_ba = do_ba;
        if (do_ab) ref_ab = rst_n ? a_in : '0;
        if (do_ba) ref_ba = rst_n ? b_in : '0;
        @(negedge clk);
        clk_ab = 1'b0;
        clk_ba = 1'b0;
    endtask

    task automatic check_all(input string tag);
        chk({"R4 ", tag}, {7'd0, b_drv}, {7'd0, oe_b});
        chk({"R4 ", tag}, {7'd0, a_drv}, {7'd0, ~oe_a_n});
        if (oe_b) begin
            chk({"R5 ", tag}, b_out, exp_b(1'b0));
            chk({"R8 ", tag}, b_out_i, exp_b(1'b1));
        end
        if (!oe_a_n) begin
            chk({"R6 ", tag}, a_out, exp_a(1'b0));
            chk({"R8 ", tag}, a_out_i, exp_a(1'b1));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        // R9: clear both registers while reset is low.
        a_in = 8'hEE; b_in = 8'hDD;
        tick(1, 1); tick(1, 1);
        rst_n = 1'b1;
        sel_ab = 1; sel_ba = 1; oe_b = 1; oe_a_n = 0;
        #1;
        chk("R9 reset B", b_out, 8'h00);
        chk("R9 reset A", a_out, 8'h00);
        chk("R8 reset inv", b_out_i, 8'hFF);

        // R3: isolation, capture still occurs.
        sel_ab = 0; sel_ba = 0; oe_b = 0; oe_a_n = 1;
        a_in = 8'hA5; b_in = 8'h3C;
        #1;
        chk("R3 iso b_drv", {7'd0, b_drv}, 8'h00);
        chk("R3 iso a_drv", {7'd0, a_drv}, 8'h00);
        tick(1, 1);
        a_in = 8'h00; b_in = 8'h00;
        sel_ab = 1; sel_ba = 1; oe_b = 1; oe_a_n = 0;
        #1;
        chk("R1 held A", b_out, 8'hA5);
        chk("R2 held B", a_out, 8'h3C);
        chk("R8 held inv B", b_out_i, 8'h5A);
        chk("R8 held inv A", a_out_i, 8'hC3);

        // R10: clocking only A-to-B keeps B-to-A.
        a_in = 8'h11; b_in = 8'h99;
        tick(1, 0);
        #1;
        chk("R10 ab updated", b_out, 8'h11);
        chk("R10 ba kept", a_out, 8'h3C);
        tick(0, 1);
        #1;
        chk("R10 ba updated", a_out, 8'h99);
        chk("R10 ab kept", b_out, 8'h11);

        // R5 / R6: live paths.
        sel_ab = 0; sel_ba = 0; a_in = 8'h77; b_in = 8'h42;
        #1;
        chk("R5 live B", b_out, 8'h77);
        chk("R6 live A", a_out, 8'h42);

        // R7: both enabled, live, same word on both buses holds.
        a_in = 8'h96; b_in = 8'h96;
        #1;
        chk("R7 echo B", b_out, 8'h96);
        chk("R7 echo A", a_out, 8'h96);

        // Random mix, including R3 capture under every control setting.
        for (int i = 0; i < 500; i++) begin
            a_in = W'($urandom); b_in = W'($urandom);
            {sel_ab, sel_ba, oe_b, oe_a_n} = 4'($urandom);
            #1;
            check_all("rand");
            tick(1'($urandom), 1'($urandom));
            {sel_ab, sel_ba, oe_b, oe_a_n} = 4'b1110;
            #1;
            chk("R1 rand held", b_out, ref_ab);
            chk("R2 rand held", a_out, ref_ba);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule